// File: doc/BRIEF.md
# Eight-Bit Flagged Arithmetic-Logic Unit

This block is the arithmetic and logic stage of a small soft-processor datapath. Each cycle it takes a destination operand from the register file and a source operand, which is either a second register value or an immediate constant from the instruction word. It also takes a five-bit operation code and the current carry and zero flags. One clock later it presents a result, a write-back enable for the destination register, and the next carry and zero flags.

The operations are bitwise AND, OR and XOR, add and subtract with and without the incoming carry, compare and test, register load, and a family of single-bit shifts and rotates. Compare and test update the flags only and request no write-back. Register load moves data and leaves both flags unchanged. Register file, decoder, memory and I/O stay outside the block. All outputs are registered. A synchronous active-high reset clears them.

Top module: `flag_alu`

## Requirements
- R1: Codes 0 (AND), 1 (OR) and 2 (XOR) apply the bitwise operation to the destination and the source, assert write-back, clear carry, and set zero when the 8-bit result is 0.
- R2: Code 3 (add) returns destination plus source. Code 4 (add-with-carry) also adds carry_i. Carry out is the unsigned overflow out of the top bit, zero comes from this 8-bit result alone, and write-back is asserted.
- R3: Code 5 (subtract) returns destination minus source. Code 6 (subtract-with-carry) also subtracts carry_i. Carry out is set on unsigned borrow, zero comes from this result, and write-back is asserted.
- R4: Code 7 (compare) sets carry and zero as subtract does, and write-back stays low.
- R5: Code 8 (test) ANDs the operands with write-back low. Zero is set when the AND is 0, and carry is its odd parity (1 when an odd number of bits is set).
- R6: Code 9 (load) returns the source with write-back asserted. The next carry and zero equal carry_i and zero_i.
- R7: The source operand is imm_i when src_imm_i is 1 and src_reg_i when it is 0.
- R8: Codes 10 to 13 shift the destination left by one bit. The vacated bit 0 is filled with 0, 1, the old bit 0, or carry_i, in that code order. Carry receives the old bit 7, zero comes from the result, and write-back is asserted.
- R9: Code 14 rotates the destination left by one bit, bit 7 entering bit 0. Carry receives the old bit 7.
- R10: Codes 15 to 18 shift the destination right by one bit. The vacated bit 7 is filled with 0, 1, the old bit 7, or carry_i, in that code order. Carry receives the old bit 0, zero comes from the result, and write-back is asserted.
- R11: Code 19 rotates the destination right by one bit, bit 0 entering bit 7. Carry receives the old bit 0.
- R12: Codes 20 to 31 return result 0 with write-back low. Carry and zero equal carry_i and zero_i.
- R13: Outputs appear on the first clock edge after the inputs are presented. An edge with rst high sets the result, write-back, carry and zero outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| dst_i | input | 8 | Destination register value (first operand) |
| src_reg_i | input | 8 | Source register value |
| imm_i | input | 8 | Immediate constant |
| src_imm_i | input | 1 | 1 selects imm_i as source |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| result_o | output | 8 | Registered result |
| wr_en_o | output | 1 | Registered destination write-back enable |
| carry_o | output | 1 | Registered next carry flag |
| zero_o | output | 1 | Registered next zero flag |

## Verification
The bench builds the block with its default data width of 8. At that width an add sweep covers every destination value, so the single overflow at 0xFF plus one is reached together with the 255 cases that must not overflow. Borrow, parity and fill bits are checked at the top and bottom bit positions where they appear. The fixed code space also lets the bench drive the unused codes at both ends of their range.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 5'd0,
    OP_OR   = 5'd1,
    OP_XOR  = 5'd2,
    OP_ADD  = 5'd3,
    OP_ADDC = 5'd4,
    OP_SUB  = 5'd5,
    OP_SUBC = 5'd6,
    OP_CMP  = 5'd7,
    OP_TST  = 5'd8,
    OP_LD   = 5'd9,
    OP_SL0  = 5'd10,
    OP_SL1  = 5'd11,
    OP_SLX  = 5'd12,
    OP_SLC  = 5'd13,
    OP_RL   = 5'd14,
    OP_SR0  = 5'd15,
    OP_SR1  = 5'd16,
    OP_SRX  = 5'd17,
    OP_SRC  = 5'd18,
    OP_RR   = 5'd19
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_SHIFT = 2'd2,
    CLS_NONE  = 2'd3
  } op_class_e;

  function automatic op_class_e classify(input logic [OP_W-1:0] code);
    if (code <= 5'd2 || code == 5'd8 || code == 5'd9) return CLS_LOGIC;
    else if (code <= 5'd7)                             return CLS_ARITH;
    else if (code <= 5'd19)                            return CLS_SHIFT;
    else                                               return CLS_NONE;
  endfunction

endpackage

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    res,
  output logic            parity_odd
);

  always_comb begin
    unique case (op)
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_LD:   res = b;
      default: res = a & b;
    endcase
  end

  assign parity_odd = ^(a & b);

endmodule

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            cout
);

  localparam int EW = W + 1;

  logic          use_cin;
  logic          is_sub;
  logic [EW-1:0] ext_a;
  logic [EW-1:0] ext_b;
  logic [EW-1:0] ext_c;
  logic [EW-1:0] total;

  assign use_cin = (op == OP_ADDC) || (op == OP_SUBC);
  assign is_sub  = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
  assign ext_a   = {1'b0, a};
  assign ext_b   = {1'b0, b};
  assign ext_c   = {{W{1'b0}}, use_cin & cin};

  always_comb begin
    if (is_sub) total = ext_a - ext_b - ext_c;
    else        total = ext_a + ext_b + ext_c;
  end

  assign res  = total[W-1:0];
  assign cout = total[W];

endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            cout
);

  logic go_left;
  logic fill;

  assign go_left = (op <= OP_RL);

  always_comb begin
    unique case (op)
      OP_SL0, OP_SR0: fill = 1'b0;
      OP_SL1, OP_SR1: fill = 1'b1;
      OP_SLX:         fill = a[0];
      OP_SRX:         fill = a[W-1];
      OP_SLC, OP_SRC: fill = cin;
      OP_RL:          fill = a[W-1];
      default:        fill = a[0];
    endcase
  end

  generate
    if (W > 1) begin : g_multi
      always_comb begin
        if (go_left) res = {a[W-2:0], fill};
        else         res = {fill, a[W-1:1]};
      end
    end else begin : g_single
      assign res = fill;
    end
  endgenerate

  assign cout = go_left ? a[W-1] : a[0];

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      op_i,
  input  logic [W-1:0]    dst_i,
  input  logic [W-1:0]    src_reg_i,
  input  logic [W-1:0]    imm_i,
  input  logic            src_imm_i,
  input  logic            carry_i,
  input  logic            zero_i,
  output logic [W-1:0]    result_o,
  output logic            wr_en_o,
  output logic            carry_o,
  output logic            zero_o
);

  logic [W-1:0] src;
  logic [W-1:0] lg_res, ar_res, sh_res;
  logic         lg_par, ar_cy, sh_cy;
  op_class_e    cls;

  logic [W-1:0] nx_res;
  logic         nx_wr, nx_cy, nx_z;

  assign src = src_imm_i ? imm_i : src_reg_i;
  assign cls = classify(op_i);

  flag_alu_logic #(.W(W)) u_logic (
    .op(op_i), .a(dst_i), .b(src), .res(lg_res), .parity_odd(lg_par)
  );

  flag_alu_arith #(.W(W)) u_arith (
    .op(op_i), .a(dst_i), .b(src), .cin(carry_i), .res(ar_res), .cout(ar_cy)
  );

  flag_alu_shift #(.W(W)) u_shift (
    .op(op_i), .a(dst_i), .cin(carry_i), .res(sh_res), .cout(sh_cy)
  );

  always_comb begin
    nx_res = '0;
    nx_wr  = 1'b0;
    nx_cy  = carry_i;
    nx_z   = zero_i;
    unique case (cls)
      CLS_LOGIC: begin
        nx_res = lg_res;
        if (op_i == OP_LD) begin
          nx_wr = 1'b1;
        end else begin
          nx_wr = (op_i != OP_TST);
          nx_cy = (op_i == OP_TST) ? lg_par : 1'b0;
          nx_z  = (lg_res == '0);
        end
      end
      CLS_ARITH: begin
        nx_res = ar_res;
        nx_wr  = (op_i != OP_CMP);
        nx_cy  = ar_cy;
        nx_z   = (ar_res == '0);
      end
      CLS_SHIFT: begin
        nx_res = sh_res;
        nx_wr  = 1'b1;
        nx_cy  = sh_cy;
        nx_z   = (sh_res == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
    end else begin
      result_o <= nx_res;
      wr_en_o  <= nx_wr;
      carry_o  <= nx_cy;
      zero_o   <= nx_z;
    end
  end

  // Output register checks
  assert_reset_clear_R13: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0 && !wr_en_o && !carry_o && !zero_o));

  assert_logic_carry_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == 5'd0 || $past(op_i) == 5'd1 || $past(op_i) == 5'd2))
    |-> (!carry_o && wr_en_o && (zero_o == (result_o == '0))));

  assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 5'd7) |-> !wr_en_o);

  assert_test_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 5'd8) |-> (!wr_en_o && (carry_o == ^result_o)));

  assert_load_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 5'd9)
    |-> (wr_en_o && carry_o == $past(carry_i) && zero_o == $past(zero_i)));

  assert_shl_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) >= 5'd10 && $past(op_i) <= 5'd14)
    |-> (carry_o == $past(dst_i[W-1]) && wr_en_o));

  assert_shr_carry_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) >= 5'd15 && $past(op_i) <= 5'd19)
    |-> (carry_o == $past(dst_i[0]) && wr_en_o));

  assert_unused_code_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) >= 5'd20)
    |-> (!wr_en_o && result_o == '0 && carry_o == $past(carry_i) && zero_o == $past(zero_i)));

endmodule

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [4:0]   op_i;
  logic [W-1:0] dst_i, src_reg_i, imm_i;
  logic         src_imm_i, carry_i, zero_i;
  logic [W-1:0] result_o;
  logic         wr_en_o, carry_o, zero_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  flag_alu #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .dst_i(dst_i), .src_reg_i(src_reg_i),
    .imm_i(imm_i), .src_imm_i(src_imm_i), .carry_i(carry_i), .zero_i(zero_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .carry_o(carry_o), .zero_o(zero_o)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] k, input logic sel, input logic c, input logic z);
    @(negedge clk);
    op_i = op; dst_i = a; src_reg_i = b; imm_i = k; src_imm_i = sel;
    carry_i = c; zero_i = z;
    @(posedge clk);
    #2;
  endtask

  task automatic expect_all(input string req, input int r, input int wr, input int c, input int z);
    chk(req, "result", result_o, r);
    chk(req, "wr_en", wr_en_o, wr);
    chk(req, "carry", carry_o, c);
    chk(req, "zero", zero_o, z);
  endtask

  task automatic t_reset;
    apply(5'd1, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    expect_all("R13", 0, 0, 0, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_logic;
    apply(5'd0, 8'hC3, 8'h5A, 8'h00, 1'b0, 1'b1, 1'b1); expect_all("R1", 8'h42, 1, 0, 0);
    apply(5'd1, 8'hC3, 8'h5A, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R1", 8'hDB, 1, 0, 0);
    apply(5'd2, 8'hC3, 8'h5A, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R1", 8'h99, 1, 0, 0);
    apply(5'd0, 8'hF0, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R1", 8'h00, 1, 0, 1);
    apply(5'd2, 8'h77, 8'h77, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R1", 8'h00, 1, 0, 1);
  endtask

  task automatic t_add;
    for (int i = 0; i < 256; i++) begin
      apply(5'd3, 8'(i), 8'h01, 8'h00, 1'b0, 1'b1, 1'b0);
      expect_all("R2", (i + 1) % 256, 1, (i == 255) ? 1 : 0, (i == 255) ? 1 : 0);
    end
    apply(5'd4, 8'h7F, 8'h80, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R2", 8'h00, 1, 1, 1);
    apply(5'd4, 8'h10, 8'h20, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R2", 8'h31, 1, 0, 0);
    apply(5'd3, 8'h10, 8'h20, 8'h00, 1'b0, 1'b1, 1'b1); expect_all("R2", 8'h30, 1, 0, 0);
  endtask

  task automatic t_sub;
    apply(5'd5, 8'h05, 8'h07, 8'h00, 1'b0, 1'b0, 1'b1); expect_all("R3", 8'hFE, 1, 1, 0);
    apply(5'd5, 8'h05, 8'h05, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R3", 8'h00, 1, 0, 1);
    apply(5'd6, 8'h05, 8'h04, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R3", 8'h00, 1, 0, 1);
    apply(5'd6, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1); expect_all("R3", 8'hFF, 1, 1, 0);
  endtask

  task automatic t_cmp_test;
    apply(5'd7, 8'h10, 8'h20, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R4", "wr_en", wr_en_o, 0); chk("R4", "carry", carry_o, 1); chk("R4", "zero", zero_o, 0);
    apply(5'd7, 8'h33, 8'h33, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R4", "wr_en", wr_en_o, 0); chk("R4", "carry", carry_o, 0); chk("R4", "zero", zero_o, 1);
    apply(5'd8, 8'h0F, 8'h07, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R5", "wr_en", wr_en_o, 0); chk("R5", "carry", carry_o, 1); chk("R5", "zero", zero_o, 0);
    apply(5'd8, 8'h03, 8'h03, 8'h00, 1'b0, 1'b1, 1'b1);
    chk("R5", "carry", carry_o, 0); chk("R5", "zero", zero_o, 0);
    apply(5'd8, 8'hF0, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R5", "carry", carry_o, 0); chk("R5", "zero", zero_o, 1);
  endtask

  task automatic t_load;
    apply(5'd9, 8'h00, 8'h11, 8'h9C, 1'b1, 1'b1, 1'b0); expect_all("R6", 8'h9C, 1, 1, 0);
    apply(5'd9, 8'hAA, 8'h00, 8'h9C, 1'b0, 1'b0, 1'b1); expect_all("R6", 8'h00, 1, 0, 1);
  endtask

  task automatic t_imm;
    apply(5'd3, 8'h01, 8'h02, 8'h40, 1'b1, 1'b0, 1'b0); expect_all("R7", 8'h41, 1, 0, 0);
    apply(5'd3, 8'h01, 8'h02, 8'h40, 1'b0, 1'b0, 1'b0); expect_all("R7", 8'h03, 1, 0, 0);
  endtask

  task automatic t_shift_left;
    apply(5'd10, 8'h81, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1); expect_all("R8", 8'h02, 1, 1, 0);
    apply(5'd11, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); expect_all("R8", 8'h03, 1, 1, 0);
    apply(5'd12, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); expect_all("R8", 8'h03, 1, 1, 0);
    apply(5'd13, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); expect_all("R8", 8'h02, 1, 1, 0);
    apply(5'd13, 8'h02, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1); expect_all("R8", 8'h05, 1, 0, 0);
    apply(5'd10, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); expect_all("R8", 8'h00, 1, 1, 1);
  endtask

  task automatic t_rotate;
    apply(5'd14, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); expect_all("R9", 8'h03, 1, 1, 0);
    apply(5'd14, 8'h40, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R9", 8'h80, 1, 0, 0);
    apply(5'd19, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); expect_all("R11", 8'hC0, 1, 1, 0);
    apply(5'd19, 8'h02, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R11", 8'h01, 1, 0, 0);
  endtask

  task automatic t_shift_right;
    apply(5'd15, 8'h81, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1); expect_all("R10", 8'h40, 1, 1, 0);
    apply(5'd16, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); expect_all("R10", 8'hC0, 1, 1, 0);
    apply(5'd17, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); expect_all("R10", 8'hC0, 1, 1, 0);
    apply(5'd18, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); expect_all("R10", 8'h40, 1, 1, 0);
    apply(5'd18, 8'h40, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R10", 8'hA0, 1, 0, 0);
    apply(5'd15, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); expect_all("R10", 8'h00, 1, 1, 1);
  endtask

  task automatic t_unused;
    apply(5'd20, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0); expect_all("R12", 0, 0, 1, 0);
    apply(5'd31, 8'h12, 8'h34, 8'h56, 1'b1, 1'b0, 1'b1); expect_all("R12", 0, 0, 0, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    op_i = '0; dst_i = '0; src_reg_i = '0; imm_i = '0;
    src_imm_i = 1'b0; carry_i = 1'b0; zero_i = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    expect_all("R13", 0, 0, 0, 0);
    @(negedge clk); rst = 1'b0;
    t_logic();
    t_add();
    t_sub();
    t_cmp_test();
    t_load();
    t_imm();
    t_shift_left();
    t_rotate();
    t_shift_right();
    t_unused();
    t_reset();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule